// File: doc/BRIEF.md
# Slow Protocol Frame Classifier

This block watches the leading bytes of every received Ethernet frame as it streams past and decides, once the frame ends, whether the frame belongs to the slow protocol family. To qualify, the frame must carry the slow-protocol EtherType and a qualifying destination address. The reserved slow-protocol multicast group always qualifies. The station's own unicast address qualifies only when unicast detection is switched on.

When detection is enabled, a qualifying frame whose subtype byte lies outside the accepted range is flagged for discard. When detection is disabled, no frame is classified, so slow protocol traffic travels on as ordinary typed frames. The block emits a one-cycle status word after each frame: a detected flag, a discard flag and the captured subtype byte. The receive datapath samples this word to steer or drop the frame. The block does not touch payload, CRC or the protocol processing itself.

Top module: `slow_frame_classifier`

## Requirements
- R1: While reset is held, and on the first cycle after it, out_valid, out_slow, out_discard and out_subtype are all zero.
- R2: A byte is taken only when in_valid is high and either in_sof is high or a frame is open. out_valid pulses for exactly one cycle, on the cycle after a taken byte that carries in_eof. Valid bytes outside a frame have no effect. Whenever out_valid is low, out_slow and out_discard are zero.
- R3: Byte 0 is the first byte of a frame (the byte taken with in_sof). Bytes 12 and 13 must equal 8'h88 and 8'h09 for the frame to be detected. Any other EtherType gives out_slow = 0.
- R4: A destination (bytes 0 to 5, in that order) of 01,80,C2,00,00,02 qualifies the frame whatever ucast_en is. A destination that differs in any byte does not qualify through this rule.
- R5: With ucast_en high, a destination equal to station_addr also qualifies. station_addr[47:40] is matched against byte 0 and station_addr[7:0] against byte 5. With ucast_en low, this match is ignored.
- R6: With detect_en low, out_slow and out_discard are zero for every frame.
- R7: Byte 14 is the subtype and appears on out_subtype for any frame that reaches it. A detected frame has out_discard = 1 exactly when the subtype is 0 or greater than 10 (values 1 to 10 are valid).
- R8: A frame that ends before byte 14 gives out_slow = 0, out_discard = 0 and out_subtype = 0. A frame whose last byte is byte 14 is classified in full.
- R9: A taken byte with in_sof while a frame is open abandons that frame without a status and starts a new frame at byte 0.
- R10: detect_en and ucast_en are used as they stand on the cycle that takes the end-of-frame byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Received byte |
| in_valid | input | 1 | in_data holds a byte this cycle |
| in_sof | input | 1 | This byte is the first of a frame |
| in_eof | input | 1 | This byte is the last of a frame |
| station_addr | input | 48 | Station unicast address, first wire byte in bits 47:40 |
| detect_en | input | 1 | Enable slow protocol classification |
| ucast_en | input | 1 | Let the station address qualify frames |
| out_valid | output | 1 | Status word valid (one cycle per frame) |
| out_slow | output | 1 | Frame detected as slow protocol |
| out_discard | output | 1 | Detected frame carries an invalid subtype |
| out_subtype | output | 8 | Captured byte 14, zero for short frames |

## Verification
The assertions assume that in_sof and in_eof mean something only when in_valid is high. They also assume that the configuration inputs are meaningful only on the cycle that closes a frame. The stimulus drives in_sof and in_eof high only together with in_valid. It also inserts stray valid bytes between frames, restarts frames partway through, and changes detect_en on the closing byte. Together these exercise the edges of those assumptions without breaking them.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
   typedef struct packed {
      logic       slow;
      logic       discard;
      logic [7:0] subtype;
   } sfc_status_t;
endpackage

// File: rtl/sfc_byte_tracker.sv
module sfc_byte_tracker #(
   parameter int IDX_W   = 4,
   parameter int IDX_CAP = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid,
   input  logic             sof,
   input  logic             eof,
   output logic             take,
   output logic             last,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] CAP = IDX_W'(IDX_CAP);

   logic             open_q;
   logic [IDX_W-1:0] cnt_q;

   assign take = valid & (sof | open_q);
   assign last = take & eof;
   assign idx  = sof ? '0 : cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
      end else if (take) begin
         open_q <= ~eof;
         cnt_q  <= (idx == CAP) ? idx : idx + 1'b1;
      end
   end
endmodule

// File: rtl/sfc_header_match.sv
module sfc_header_match #(
   parameter int              ADDR_BYTES    = 6,
   parameter int              IDX_W         = 4,
   parameter logic [47:0]     GROUP_ADDR    = 48'h0180_C200_0002,
   parameter logic [15:0]     SLOW_ETYPE    = 16'h8809,
   parameter bit              UCAST_SUPPORT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  take,
   input  logic [IDX_W-1:0]      idx,
   input  logic [7:0]            data,
   input  logic [8*ADDR_BYTES-1:0] station_addr,
   output logic                  grp_ok,
   output logic                  stn_ok,
   output logic                  type_ok,
   output logic [7:0]            sub_q
);
   localparam int SEL_W     = $clog2(ADDR_BYTES);
   localparam int TAB_N     = 1 << SEL_W;
   localparam int ETYPE_OFS = 2 * ADDR_BYTES;
   localparam int SUB_OFS   = ETYPE_OFS + 2;
   localparam logic [IDX_W-1:0] I_ET_HI = IDX_W'(ETYPE_OFS);
   localparam logic [IDX_W-1:0] I_ET_LO = IDX_W'(ETYPE_OFS + 1);
   localparam logic [IDX_W-1:0] I_SUB   = IDX_W'(SUB_OFS);
   localparam logic [IDX_W-1:0] I_NDA   = IDX_W'(ADDR_BYTES);

   logic [7:0]       grp_tab [TAB_N];
   logic [7:0]       stn_tab [TAB_N];
   logic [SEL_W-1:0] sel;
   logic             in_da;
   logic             first;

   assign sel   = idx[SEL_W-1:0];
   assign in_da = (idx < I_NDA);
   assign first = (idx == '0);

   for (genvar i = 0; i < TAB_N; i++) begin : g_tab
      if (i < ADDR_BYTES) begin : g_live
         assign grp_tab[i] = GROUP_ADDR[8*(ADDR_BYTES-1-i) +: 8];
         assign stn_tab[i] = station_addr[8*(ADDR_BYTES-1-i) +: 8];
      end else begin : g_pad
         assign grp_tab[i] = 8'h00;
         assign stn_tab[i] = 8'h00;
      end
   end

   logic grp_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grp_q   <= 1'b0;
         type_ok <= 1'b0;
         sub_q   <= 8'h00;
      end else if (take) begin
         if (in_da) grp_q <= (first | grp_q) & (data == grp_tab[sel]);
         if (first) begin
            type_ok <= 1'b0;
            sub_q   <= 8'h00;
         end
         if (idx == I_ET_HI) type_ok <= (data == SLOW_ETYPE[15:8]);
         if (idx == I_ET_LO) type_ok <= type_ok & (data == SLOW_ETYPE[7:0]);
         if (idx == I_SUB)   sub_q   <= data;
      end
   end
   assign grp_ok = grp_q;

   if (UCAST_SUPPORT) begin : g_ucast
      logic stn_q;
      always_ff @(posedge clk) begin
         if (!rst_n)             stn_q <= 1'b0;
         else if (take && in_da) stn_q <= (first | stn_q) & (data == stn_tab[sel]);
      end
      assign stn_ok = stn_q;
   end else begin : g_no_ucast
      assign stn_ok = 1'b0;
   end
endmodule

// File: rtl/sfc_verdict.sv
module sfc_verdict #(
   parameter int IDX_W   = 4,
   parameter int SUB_OFS = 14,
   parameter int SUB_MIN = 1,
   parameter int SUB_MAX = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                last,
   input  logic [IDX_W-1:0]    idx,
   input  logic [7:0]          data,
   input  logic [7:0]          sub_q,
   input  logic                grp_ok,
   input  logic                stn_ok,
   input  logic                type_ok,
   input  logic                detect_en,
   input  logic                ucast_en,
   output logic                stat_vld,
   output sfc_pkg::sfc_status_t stat
);
   localparam logic [IDX_W-1:0] I_SUB = IDX_W'(SUB_OFS);
   localparam logic [7:0]       LO    = 8'(SUB_MIN);
   localparam logic [7:0]       HI    = 8'(SUB_MAX);

   logic       has_sub;
   logic [7:0] sub_now;
   logic       addr_ok;
   logic       hit;
   logic       sub_good;
   sfc_pkg::sfc_status_t nxt;

   assign has_sub  = (idx >= I_SUB);
   assign sub_now  = !has_sub ? 8'h00 : ((idx == I_SUB) ? data : sub_q);
   assign addr_ok  = grp_ok | (ucast_en & stn_ok);
   assign hit      = detect_en & has_sub & type_ok & addr_ok;
   assign sub_good = (sub_now >= LO) && (sub_now <= HI);

   always_comb begin
      nxt.slow    = hit;
      nxt.discard = hit & ~sub_good;
      nxt.subtype = sub_now;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_vld <= 1'b0;
         stat     <= '0;
      end else begin
         stat_vld <= last;
         stat     <= last ? nxt : '0;
      end
   end
endmodule

// File: rtl/slow_frame_classifier.sv
module slow_frame_classifier #(
   parameter int          ADDR_BYTES    = 6,
   parameter logic [47:0] GROUP_ADDR    = 48'h0180_C200_0002,
   parameter logic [15:0] SLOW_ETYPE    = 16'h8809,
   parameter int          SUB_MIN       = 1,
   parameter int          SUB_MAX       = 10,
   parameter bit          UCAST_SUPPORT = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [7:0]              in_data,
   input  logic                    in_valid,
   input  logic                    in_sof,
   input  logic                    in_eof,
   input  logic [8*ADDR_BYTES-1:0] station_addr,
   input  logic                    detect_en,
   input  logic                    ucast_en,
   output logic                    out_valid,
   output logic                    out_slow,
   output logic                    out_discard,
   output logic [7:0]              out_subtype
);
   localparam int SUB_OFS = 2 * ADDR_BYTES + 2;
   localparam int IDX_CAP = SUB_OFS + 1;
   localparam int IDX_W   = $clog2(IDX_CAP + 1);

   if (ADDR_BYTES < 2 || ADDR_BYTES > 6) begin : g_bad_addr
      $error("ADDR_BYTES must lie in 2..6");
   end
   if (SUB_MIN > SUB_MAX || SUB_MAX > 255 || SUB_MIN < 0) begin : g_bad_range
      $error("subtype range must satisfy 0 <= SUB_MIN <= SUB_MAX <= 255");
   end

   logic             take;
   logic             last;
   logic [IDX_W-1:0] idx;
   logic             grp_ok;
   logic             stn_ok;
   logic             type_ok;
   logic [7:0]       sub_q;
   logic             stat_vld;
   sfc_pkg::sfc_status_t stat;

   sfc_byte_tracker #(.IDX_W(IDX_W), .IDX_CAP(IDX_CAP)) u_track (
      .clk(clk), .rst_n(rst_n), .valid(in_valid), .sof(in_sof), .eof(in_eof),
      .take(take), .last(last), .idx(idx)
   );

   sfc_header_match #(
      .ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W), .GROUP_ADDR(GROUP_ADDR),
      .SLOW_ETYPE(SLOW_ETYPE), .UCAST_SUPPORT(UCAST_SUPPORT)
   ) u_match (
      .clk(clk), .rst_n(rst_n), .take(take), .idx(idx), .data(in_data),
      .station_addr(station_addr), .grp_ok(grp_ok), .stn_ok(stn_ok),
      .type_ok(type_ok), .sub_q(sub_q)
   );

   sfc_verdict #(
      .IDX_W(IDX_W), .SUB_OFS(SUB_OFS), .SUB_MIN(SUB_MIN), .SUB_MAX(SUB_MAX)
   ) u_verdict (
      .clk(clk), .rst_n(rst_n), .last(last), .idx(idx), .data(in_data),
      .sub_q(sub_q), .grp_ok(grp_ok), .stn_ok(stn_ok), .type_ok(type_ok),
      .detect_en(detect_en), .ucast_en(ucast_en),
      .stat_vld(stat_vld), .stat(stat)
   );

   assign out_valid   = stat_vld;
   assign out_slow    = stat.slow;
   assign out_discard = stat.discard;
   assign out_subtype = stat.subtype;
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_eof,
   input logic       detect_en,
   input logic       out_valid,
   input logic       out_slow,
   input logic       out_discard,
   input logic [7:0] out_subtype
);
   // R2
   status_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid && in_eof));
   // R2
   quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!out_slow && !out_discard));
   // R6
   slow_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_slow |-> $past(detect_en));
   // R7
   discard_implies_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_discard |-> out_slow);
   // R7
   good_subtype_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_slow && out_subtype >= 8'd1 && out_subtype <= 8'd10) |-> !out_discard);
   // R7
   bad_subtype_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_slow && (out_subtype == 8'd0 || out_subtype > 8'd10)) |-> out_discard);
endmodule

bind slow_frame_classifier sfc_checker u_sfc_checker (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eof(in_eof),
   .detect_en(detect_en), .out_valid(out_valid), .out_slow(out_slow),
   .out_discard(out_discard), .out_subtype(out_subtype)
);

// File: tb/test_slow_frame_classifier.sv
`timescale 1ns/1ps
module test_slow_frame_classifier;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
   logic [47:0] station_addr = 48'h02AB_CD12_3456;
   logic        detect_en = 1'b1, ucast_en = 1'b0;
   logic        out_valid, out_slow, out_discard;
   logic [7:0]  out_subtype;

   localparam logic [47:0] GRP = 48'h0180_C200_0002;

   always #2.5 clk = ~clk;

   slow_frame_classifier i_slow_frame_classifier (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
      .in_sof(in_sof), .in_eof(in_eof), .station_addr(station_addr),
      .detect_en(detect_en), .ucast_en(ucast_en), .out_valid(out_valid),
      .out_slow(out_slow), .out_discard(out_discard), .out_subtype(out_subtype)
   );

   int     vectors = 0, errors = 0, cycles = 0;
   string  cur_req = "R1";
   bit     done = 1'b0;

   // behavioural reference model
   logic [7:0] mq[$];
   bit         mopen = 1'b0;
   logic       e_v = 0, e_s = 0, e_d = 0;
   logic [7:0] e_sub = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete(); mopen = 1'b0;
         e_v <= 0; e_s <= 0; e_d <= 0; e_sub <= 0;
      end else begin
         bit got, da_grp, da_stn, ok;
         logic [7:0] sb;
         got = in_valid && (in_sof || mopen);
         if (in_valid && in_sof) begin mq.delete(); mq.push_back(in_data); end
         else if (got) mq.push_back(in_data);
         if (got) mopen = !in_eof;
         if (got && in_eof) begin
            da_grp = mq.size() >= 6; da_stn = mq.size() >= 6;
            for (int i = 0; i < 6; i++) if (i < mq.size()) begin
               if (mq[i] != GRP[47-8*i -: 8]) da_grp = 0;
               if (mq[i] != station_addr[47-8*i -: 8]) da_stn = 0;
            end
            sb = (mq.size() >= 15) ? mq[14] : 8'h00;
            ok = detect_en && mq.size() >= 15 && mq[12] == 8'h88 && mq[13] == 8'h09
                 && (da_grp || (ucast_en && da_stn));
            e_v <= 1; e_s <= ok; e_d <= ok && (sb == 0 || sb > 10); e_sub <= sb;
         end else begin
            e_v <= 0; e_s <= 0; e_d <= 0; e_sub <= 0;
         end
      end
   end

   always @(negedge clk) if (!done) begin
      cycles++;
      vectors++;
      if ({out_valid, out_slow, out_discard, out_subtype} !== {e_v, e_s, e_d, e_sub}) begin
         errors++;
         $display("FAIL %s: got v=%b s=%b d=%b sub=%h expected v=%b s=%b d=%b sub=%h",
                  cur_req, out_valid, out_slow, out_discard, out_subtype,
                  e_v, e_s, e_d, e_sub);
      end
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog: got hung run expected completion");
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   logic [7:0] fr[$];

   task automatic build(input logic [47:0] da, input logic [15:0] et,
                        input logic [7:0] sub, input int len);
      fr.delete();
      for (int i = 0; i < len; i++) begin
         logic [7:0] b;
         if (i < 6)       b = da[47-8*i -: 8];
         else if (i < 12) b = 8'hA0 + 8'(i);
         else if (i == 12) b = et[15:8];
         else if (i == 13) b = et[7:0];
         else if (i == 14) b = sub;
         else              b = 8'(i * 7);
         fr.push_back(b);
      end
   endtask

   // play the frame; cut>0 stops after cut bytes without eof; det_last >=0 sets detect_en on last byte
   task automatic play(input int cut, input int det_last, input int gap);
      int n;
      n = (cut > 0) ? cut : fr.size();
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         in_valid = 1; in_data = fr[i];
         in_sof = (i == 0);
         in_eof = (cut == 0) && (i == n - 1);
         if (in_eof && det_last >= 0) detect_en = det_last[0];
      end
      @(posedge clk); #1;
      in_valid = 0; in_sof = 0; in_eof = 0;
      for (int g = 0; g < gap; g++) @(posedge clk);
   endtask

   task automatic stray(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1; in_valid = 1; in_data = 8'h0D; in_sof = 0; in_eof = 1;
      end
      @(posedge clk); #1; in_valid = 0; in_eof = 0;
   endtask

   initial begin
      cur_req = "R1";  // reset state
      repeat (4) @(posedge clk);
      #1 rst_n = 1;
      repeat (2) @(posedge clk);

      cur_req = "R4"; build(GRP, 16'h8809, 8'd3, 60);  play(0, -1, 3);
      build(GRP ^ 48'h1, 16'h8809, 8'd3, 60);           play(0, -1, 2);
      cur_req = "R7"; build(GRP, 16'h8809, 8'd0, 40);   play(0, -1, 2);
      build(GRP, 16'h8809, 8'd1, 40);                   play(0, -1, 2);
      build(GRP, 16'h8809, 8'd10, 40);                  play(0, -1, 2);
      build(GRP, 16'h8809, 8'd11, 40);                  play(0, -1, 2);
      build(GRP, 16'h8809, 8'hFF, 40);                  play(0, -1, 0);
      cur_req = "R3"; build(GRP, 16'h8808, 8'd2, 40);   play(0, -1, 2);
      build(GRP, 16'h8909, 8'd2, 40);                   play(0, -1, 2);
      cur_req = "R5"; ucast_en = 1;
      build(station_addr, 16'h8809, 8'd4, 30);          play(0, -1, 2);
      build(station_addr, 16'h8809, 8'd0, 30);          play(0, -1, 2);
      ucast_en = 0;
      build(station_addr, 16'h8809, 8'd4, 30);          play(0, -1, 2);
      cur_req = "R6"; detect_en = 0;
      build(GRP, 16'h8809, 8'd0, 30);                   play(0, -1, 2);
      build(GRP, 16'h8809, 8'd5, 30);                   play(0, -1, 2);
      detect_en = 1;
      cur_req = "R8"; build(GRP, 16'h8809, 8'd3, 14);   play(0, -1, 2);
      build(GRP, 16'h8809, 8'd3, 15);                   play(0, -1, 2);
      build(GRP, 16'h8809, 8'd0, 15);                   play(0, -1, 2);
      build(GRP, 16'h8809, 8'd3, 1);                    play(0, -1, 2);
      cur_req = "R9"; build(GRP, 16'h8809, 8'd0, 40);   play(9, -1, 0);
      build(GRP, 16'h8809, 8'd6, 30);                   play(0, -1, 2);
      build(station_addr, 16'h8809, 8'd6, 30);          play(20, -1, 0);
      build(GRP, 16'h8808, 8'd6, 30);                   play(0, -1, 2);
      cur_req = "R2"; stray(3);
      build(GRP, 16'h8809, 8'd7, 20);                   play(0, -1, 0);
      stray(2);
      build(GRP, 16'h8809, 8'd8, 20);                   play(0, -1, 3);
      cur_req = "R10"; detect_en = 0;
      build(GRP, 16'h8809, 8'd9, 25);                   play(0, 1, 2);
      build(GRP, 16'h8809, 8'd9, 25);                   play(0, 0, 2);
      detect_en = 1; ucast_en = 1;
      build(station_addr, 16'h8809, 8'd12, 25);         play(0, -1, 4);
      ucast_en = 0;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule